// File: doc/BRIEF.md
# Daisy-Chain Serial Command Port with Frame-Length Check

This block is the serial front end of a command/status device. It accepts 16-bit command words from a full-duplex four-wire serial bus and returns a 16-bit status word over the same frames. It can sit in a chain with other 8-bit and 16-bit devices. The host drives chip select, the serial clock and serial data in. The block drives serial data out together with an output-enable line that stands in for the tri-state pad. All bus pins are oversampled in the system clock domain through two-flop synchronizers. Edges are found on the synchronized copies.

When a frame starts, the status word is frozen. The output first carries a thermal-fault pseudo-bit, formed as the OR of the fault flag and the incoming data line, so that a latched fault ripples down the whole chain. The status bits then follow, most significant first. After those, the data received earlier is passed along, delayed by sixteen clocks. The frame length is checked against a modulus that is sixteen for the first word and eight after that. When chip select returns high after a well-formed frame, the last sixteen bits received are written to the command register and a one-cycle write strobe is raised.

Top module: `spi_chain_slave`

## Requirements
- R1: While chip select is high, `sdo_oe` is 0 and `sdo_out` is 0.
- R2: From the falling edge of chip select until the first rising serial clock edge, `sdo_out` equals `tsd_flag` OR `sdi_in`.
- R3: After the k-th rising serial clock edge of a frame (k = 1..16), `sdo_out` carries bit 16-k of the status word, so bit 15 is sent first.
- R4: The status word is captured when chip select falls. Changes on `sts_word` during the frame do not alter the bits shifted out.
- R5: After rising edge k > 16, `sdo_out` carries the data bit that was received in position k-16 of the frame (position 1 being the first bit sent).
- R6: Data in is sampled on falling serial clock edges. When chip select rises after N rising clock edges, with N ≥ 16 and N a multiple of 8, `cmd_word` takes the last 16 bits received (the earliest of them in bit 15) and `cmd_wr` pulses for exactly one cycle.
- R7: A frame with fewer than 16 clocks, or with a clock count that is not a multiple of 8, leaves `cmd_word` unchanged and raises no `cmd_wr`.
- R8: While `rst` is high and after its release, `cmd_word` is 0 and `cmd_wr` is 0 until a valid frame completes.
- R9: A final falling clock edge that is seen in the same synchronized sample as the rising edge of chip select is still captured and committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| csb_in | input | 1 | Chip select, active low |
| sclk_in | input | 1 | Serial clock, idle low |
| sdi_in | input | 1 | Serial data in |
| tsd_flag | input | 1 | Latched thermal-shutdown flag for the pseudo-bit |
| sts_word | input | 16 | Parallel status word to return |
| sdo_out | output | 1 | Serial data out, 0 when disabled |
| sdo_oe | output | 1 | Output enable of the serial data pad |
| cmd_word | output | 16 | Committed command register |
| cmd_wr | output | 1 | One-cycle strobe when `cmd_word` is written |

## Verification
Two functions can land in the same system cycle: capture of the final data bit on a falling clock edge, and the commit triggered by the rising edge of chip select. When both pins change together, the synchronizers deliver both transitions in one sample. A directed frame drops the serial clock and raises chip select at the same instant, and it ends with a data bit that differs from the previous one. The check passes only when the committed word includes that final bit and exactly one strobe occurred. The frozen status word is also tested against a live status change made after the first clock edge.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int SPC_WORD_W = 16;
    localparam int SPC_STEP_W = 8;
    localparam int SPC_SYNC_N = 2;

    typedef enum logic [0:0] {
        PH_FIRST = 1'b0,
        PH_TAIL  = 1'b1
    } frame_phase_e;

    typedef struct packed {
        logic csb_fall;
        logic csb_rise;
        logic sclk_rise;
        logic sclk_fall;
    } bus_evt_t;

    function automatic logic pseudo_bit(input logic fault, input logic din);
        return fault | din;
    endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= RST_VAL;
                end else if (s == 0) begin
                    stg[s] <= d;
                end else begin
                    stg[s] <= stg[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spc_edge.sv
module spc_edge
    import spc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     csb_s,
    input  logic     sclk_s,
    output bus_evt_t ev
);
    logic csb_d;
    logic sclk_d;
    logic in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            csb_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csb_d  <= csb_s;
            sclk_d <= sclk_s;
        end
    end

    // a clock edge belongs to a frame when chip select was low at the previous sample
    assign in_frame = ~csb_d;

    always_comb begin
        ev.csb_fall  = csb_d & ~csb_s;
        ev.csb_rise  = ~csb_d & csb_s;
        ev.sclk_rise = in_frame & ~sclk_d & sclk_s;
        ev.sclk_fall = in_frame & sclk_d & ~sclk_s;
    end
endmodule

// File: rtl/spc_framecnt.sv
module spc_framecnt
    import spc_pkg::*;
#(
    parameter int FIRST = SPC_WORD_W,
    parameter int STEP  = SPC_STEP_W
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic frame_ok
);
    localparam int CNT_W = (FIRST > 1) ? $clog2(FIRST) : 1;
    localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(FIRST - 1);
    localparam logic [CNT_W-1:0] STEP_LAST  = CNT_W'(STEP - 1);

    frame_phase_e     phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= PH_FIRST;
            cnt   <= '0;
        end else if (tick) begin
            if (phase == PH_FIRST) begin
                if (cnt == FIRST_LAST) begin
                    cnt   <= '0;
                    phase <= PH_TAIL;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= (cnt == STEP_LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign frame_ok = (phase == PH_TAIL) && (cnt == '0);
endmodule

// File: rtl/spc_shift.sv
module spc_shift
    import spc_pkg::*;
#(
    parameter int W = SPC_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] snap,
    input  logic         rise,
    input  logic         fall,
    input  logic         din,
    output logic         tx_bit,
    output logic         pseudo_act,
    output logic [W-1:0] rx_next
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    assign rx_next = fall ? {rx_q[W-2:0], din} : rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q       <= '0;
            rx_q       <= '0;
            pseudo_act <= 1'b0;
        end else begin
            rx_q <= rx_next;
            if (load) begin
                tx_q       <= snap;
                pseudo_act <= 1'b1;
            end else if (rise) begin
                if (pseudo_act) begin
                    pseudo_act <= 1'b0;
                end else begin
                    // refill from the newest received bit: chain data follows 16 clocks later
                    tx_q <= {tx_q[W-2:0], rx_q[0]};
                end
            end
        end
    end

    assign tx_bit = tx_q[W-1];
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
    import spc_pkg::*;
#(
    parameter int WORD_W = SPC_WORD_W,
    parameter int STEP_W = SPC_STEP_W,
    parameter int SYNC_N = SPC_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csb_in,
    input  logic              sclk_in,
    input  logic              sdi_in,
    input  logic              tsd_flag,
    input  logic [WORD_W-1:0] sts_word,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] cmd_word,
    output logic              cmd_wr
);
    localparam logic [2:0] SYNC_RST = 3'b100;

    logic [2:0]        pins_s;
    logic              csb_s;
    logic              sclk_s;
    logic              sdi_s;
    bus_evt_t          ev;
    logic              frame_ok;
    logic              tx_bit;
    logic              pseudo_act;
    logic [WORD_W-1:0] rx_next;
    logic              csb_rise_w;
    logic              show_pseudo;

    spc_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({csb_in, sclk_in, sdi_in}),
        .q   (pins_s)
    );

    assign csb_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    spc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .csb_s  (csb_s),
        .sclk_s (sclk_s),
        .ev     (ev)
    );

    spc_framecnt #(.FIRST(WORD_W), .STEP(STEP_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (ev.csb_fall),
        .tick     (ev.sclk_rise),
        .frame_ok (frame_ok)
    );

    spc_shift #(.W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (ev.csb_fall),
        .snap       (sts_word),
        .rise       (ev.sclk_rise),
        .fall       (ev.sclk_fall),
        .din        (sdi_s),
        .tx_bit     (tx_bit),
        .pseudo_act (pseudo_act),
        .rx_next    (rx_next)
    );

    assign csb_rise_w  = ev.csb_rise;
    assign show_pseudo = pseudo_act | ev.csb_fall;
    assign sdo_oe      = ~csb_s;
    assign sdo_out     = sdo_oe & (show_pseudo ? pseudo_bit(tsd_flag, sdi_s) : tx_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word <= '0;
            cmd_wr   <= 1'b0;
        end else begin
            cmd_wr <= 1'b0;
            if (ev.csb_rise && frame_ok) begin
                cmd_word <= rx_next;
                cmd_wr   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] cmd_word,
    input logic              cmd_wr,
    input logic              sdo_oe,
    input logic              sdo_out,
    input logic              tsd_flag,
    input logic              sdi_s,
    input logic              csb_rise,
    input logic              frame_ok
);
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cmd_word == '0) && !cmd_wr);

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_word != $past(cmd_word)) |-> cmd_wr);

    // R6
    commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> ($past(csb_rise) && $past(frame_ok)));

    // R2
    pseudo_first_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !$past(sdo_oe)) |-> (sdo_out == (tsd_flag | sdi_s)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo_out);
endmodule

bind spi_chain_slave spc_checker #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_word (cmd_word),
    .cmd_wr   (cmd_wr),
    .sdo_oe   (sdo_oe),
    .sdo_out  (sdo_out),
    .tsd_flag (tsd_flag),
    .sdi_s    (sdi_s),
    .csb_rise (csb_rise_w),
    .frame_ok (frame_ok)
);

// File: tb/spi_chain_slave_tb_top.sv
module spi_chain_slave_tb_top;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csb_in = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sdi_in = 1'b0;
    logic        tsd_flag = 1'b0;
    logic [15:0] sts_word = '0;
    logic        sdo_out;
    logic        sdo_oe;
    logic [15:0] cmd_word;
    logic        cmd_wr;

    int total = 0;
    int bad = 0;
    int wr_seen = 0;
    logic [15:0] model_cmd = '0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_chain_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .csb_in   (csb_in),
        .sclk_in  (sclk_in),
        .sdi_in   (sdi_in),
        .tsd_flag (tsd_flag),
        .sts_word (sts_word),
        .sdo_out  (sdo_out),
        .sdo_oe   (sdo_oe),
        .cmd_word (cmd_word),
        .cmd_wr   (cmd_wr)
    );

    always @(posedge clk) if (cmd_wr) wr_seen <= wr_seen + 1;

    task automatic tick(input int c);
        repeat (c) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_so(input int k, input logic [15:0] sts, input logic [63:0] bits);
        if (k <= 16) return sts[16-k];
        return bits[k-17];
    endfunction

    function automatic bit frame_valid(input int n);
        return (n >= 16) && (n % 8 == 0);
    endfunction

    function automatic logic [15:0] last16(input int n, input logic [63:0] bits);
        logic [15:0] w;
        for (int j = 0; j < 16; j++) w[15-j] = bits[n-16+j];
        return w;
    endfunction

    task automatic run_frame(input int n, input logic [63:0] bits, input logic [15:0] sts,
                             input logic tsd, input logic si_pre, input bit collide);
        int wr0;
        chk("R1 idle oe", {31'd0, sdo_oe}, 32'd0);
        chk("R1 idle sdo", {31'd0, sdo_out}, 32'd0);
        sts_word = sts;
        tsd_flag = tsd;
        sdi_in   = si_pre;
        tick(HALF);
        wr0 = wr_seen;
        csb_in = 1'b0;
        tick(HALF);
        chk("R2 pseudo", {31'd0, sdo_out}, {31'd0, tsd | si_pre});
        for (int i = 0; i < n; i++) begin
            sdi_in = bits[i];
            tick(HALF);
            sclk_in = 1'b1;
            tick(HALF);
            if (i == 0) sts_word = 16'($urandom);
            if (i + 1 <= 16)
                chk((i == 0) ? "R3 status msb" : "R4 frozen status", {31'd0, sdo_out},
                    {31'd0, exp_so(i + 1, sts, bits)});
            else
                chk("R5 chain pass", {31'd0, sdo_out}, {31'd0, exp_so(i + 1, sts, bits)});
            sclk_in = 1'b0;
            if (collide && i == n - 1) csb_in = 1'b1;
            tick(HALF);
        end
        csb_in = 1'b1;
        tick(2 * HALF);
        if (frame_valid(n)) begin
            model_cmd = last16(n, bits);
            chk(collide ? "R9 collide commit" : "R6 commit", {16'd0, cmd_word}, {16'd0, model_cmd});
            chk("R6 strobe count", 32'(wr_seen - wr0), 32'd1);
        end else begin
            chk("R7 kept", {16'd0, cmd_word}, {16'd0, model_cmd});
            chk("R7 no strobe", 32'(wr_seen - wr0), 32'd0);
        end
    endtask

    initial begin
        int lens [10] = '{8, 12, 15, 16, 17, 20, 24, 25, 32, 40};
        logic [63:0] b;
        void'($urandom(32'd1234));
        tick(6);
        chk("R8 reset cmd", {16'd0, cmd_word}, 32'd0);
        chk("R8 reset wr", {31'd0, cmd_wr}, 32'd0);
        rst = 1'b0;
        tick(4);
        chk("R8 after release", {16'd0, cmd_word}, 32'd0);
        chk("R1 after reset", {31'd0, sdo_oe}, 32'd0);

        run_frame(16, 64'h0000_0000_0000_A5C3, 16'h8001, 1'b0, 1'b0, 0);
        run_frame(16, 64'h0000_0000_0000_3C5A, 16'h1234, 1'b1, 1'b0, 0);
        run_frame(24, 64'h0000_0000_00F0_0F96, 16'hFEDC, 1'b0, 1'b1, 0);
        run_frame(8,  64'h0000_0000_0000_00FF, 16'h5555, 1'b1, 1'b1, 0);
        run_frame(15, 64'h0000_0000_0000_7FFF, 16'hAAAA, 1'b0, 1'b0, 0);
        run_frame(17, 64'h0000_0000_0001_FFFF, 16'h0F0F, 1'b0, 1'b0, 0);
        run_frame(32, 64'h0000_0000_DEAD_BEEF, 16'hC0DE, 1'b0, 1'b0, 0);
        // last bit differs from the one before it: lost capture would shift the word
        run_frame(16, 64'h0000_0000_0000_8123, 16'h4321, 1'b0, 1'b0, 1);

        for (int r = 0; r < 40; r++) begin
            b = {$urandom, $urandom};
            run_frame(lens[$urandom % 10], b, 16'($urandom), 1'($urandom), 1'($urandom),
                      ($urandom % 5) == 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule